// File: doc/BRIEF.md
# Gated Parallel-to-Serial Shift Register

This block turns a byte presented in parallel into a bit stream. It has a chain of eight storage stages, numbered from the first stage (stage 0) to the last stage (stage 7). On a rising clock edge the chain does one of three things. It can take a whole byte from the parallel inputs. It can step every stage one place toward the last stage, taking a new bit from the serial input into stage 0. Or it can keep its contents. Only the last stage is driven onto the serial output.

The `hold_en` input freezes the chain. It is sampled at the clock edge as a clock enable; the clock net itself is never gated. The `shift_sel` input chooses between loading and shifting. An active-low clear empties the chain at once, whatever the clock is doing. A typical use is to load a byte and then apply eight shift edges with the serial input at 0. The byte then leaves the block last-stage bit first, and the chain is left empty.

Top module: `gated_p2s_shifter`

## Requirements
- R1: While `clr_n` is 0, every stage and `ser_out` are 0. This holds at once, without waiting for a clock edge, and whatever the other inputs are doing.
- R2: At a rising edge with `clr_n`=1 and `hold_en`=1, no stage changes, whatever `shift_sel`, `ser_in` and `par_in` are.
- R3: At a rising edge with `clr_n`=1, `hold_en`=0 and `shift_sel`=0, stage k takes `par_in[k]`. Stage 0 is the first stage and stage 7 is the last, so `ser_out` then equals `par_in[7]`.
- R4: At a rising edge with `clr_n`=1, `hold_en`=0 and `shift_sel`=1, stage 0 takes `ser_in` and stage k takes the old stage k-1. The old content of stage 7 is lost.
- R5: `ser_out` always equals stage 7. No other stage drives an output.
- R6: Between rising edges, with `clr_n`=1, all stages keep their values.
- R7: Clear acts as soon as it goes low. After `clr_n` returns to 1, the first load or shift happens on the next rising edge, and the chain reads all zeros until that edge.
- R8: After a load, eight shift edges with `ser_in`=0 present `par_in[7]`, `par_in[6]`, ... `par_in[0]` on `ser_out`, in that order. The chain is then all zeros.
- R9: `shift_sel`, `ser_in` and `par_in` matter only at the rising edge. Changing them between edges has no effect.
- R10: During a load, `ser_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the stages update on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| hold_en | input | 1 | Synchronous freeze, active high |
| shift_sel | input | 1 | 0 = parallel load, 1 = serial shift |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | 8 | Parallel data; bit k goes to stage k |
| ser_out | output | 1 | Content of stage 7 |

## Verification
Only stage 7 is visible, so a wrong bit in stage k does not show at the ports until 7-k shift edges later. A stage stuck at some value, or a wrong load mapping, shows only when the chain is shifted out. For that reason each scenario ends by shifting the whole chain out, so that every stage's content is compared within eight cycles. Clear faults and freeze faults show at `ser_out` within one edge, or immediately for clear. Order faults show as a reversed or misplaced bit in the eight-edge drain sequence.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  // Action the stage chain takes at the next rising edge.
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } act_e;
endpackage

// File: rtl/p2s_mode_decode.sv
module p2s_mode_decode
  import p2s_pkg::*;
(
  input  logic hold_en,
  input  logic shift_sel,
  output act_e act,
  output logic do_load,
  output logic do_shift
);
  // Freeze wins over everything; otherwise the select picks load or shift.
  always_comb begin
    if (hold_en)        act = ACT_KEEP;
    else if (shift_sel) act = ACT_SHIFT;
    else                act = ACT_LOAD;
  end

  assign do_load  = (act == ACT_LOAD);
  assign do_shift = (act == ACT_SHIFT);
endmodule

// File: rtl/p2s_stage_chain.sv
module p2s_stage_chain
  import p2s_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  act_e              act,
  input  logic              do_load,
  input  logic              do_shift,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] q
);
  localparam int LAST = STAGES - 1;

  // Next content of the chain for a given action.
  function automatic logic [STAGES-1:0] advance(
    input act_e              a,
    input logic [STAGES-1:0] cur,
    input logic [STAGES-1:0] par,
    input logic              sin
  );
    logic [STAGES-1:0] nxt;
    case (a)
      ACT_LOAD:  nxt = par;
      ACT_SHIFT: nxt = {cur[LAST-1:0], sin};
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  logic [STAGES-1:0] q_next;
  assign q_next = advance(act, q, par_in, ser_in);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q[k] <= 1'b0;
      else        q[k] <= q_next[k];
    end
  end

  // Clear empties the chain, checked away from the active edge.
  p_clear_empty_r1: assert property (@(negedge clk) !clr_n |-> (q == '0));

  // A frozen edge changes nothing.
  p_freeze_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (!do_load && !do_shift) |=> $stable(q));

  // A load edge copies the parallel word.
  p_load_map_r3: assert property (@(posedge clk) disable iff (!clr_n)
    do_load |=> (q == $past(par_in)));

  // A shift edge moves each stage up one place and takes the serial bit.
  p_shift_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
    do_shift |=> (q[0] == $past(ser_in)) && (q[LAST:1] == $past(q[LAST-1:0])));

  // The chain is still empty at the edge that first sees clear released.
  p_release_empty_r7: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (q == '0));

  // Load and shift never both fire.
  p_one_action_r10: assert property (@(posedge clk) disable iff (!clr_n)
    !(do_load && do_shift));
endmodule

// File: rtl/gated_p2s_shifter.sv
module gated_p2s_shifter
  import p2s_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              hold_en,
  input  logic              shift_sel,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              ser_out
);
  localparam int LAST = STAGES - 1;

  act_e              act;
  logic              do_load;
  logic              do_shift;
  logic [STAGES-1:0] q;

  p2s_mode_decode u_decode (
    .hold_en   (hold_en),
    .shift_sel (shift_sel),
    .act       (act),
    .do_load   (do_load),
    .do_shift  (do_shift)
  );

  p2s_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .clr_n    (clr_n),
    .act      (act),
    .do_load  (do_load),
    .do_shift (do_shift),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .q        (q)
  );

  assign ser_out = q[LAST];

  // After a load, the serial output shows the last parallel bit.
  p_out_after_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
    do_load |=> (ser_out == $past(par_in[LAST])));

  // After a freeze edge, the serial output holds.
  p_out_frozen_r2: assert property (@(posedge clk) disable iff (!clr_n)
    hold_en |=> $stable(ser_out));
endmodule

// File: tb/test_gated_p2s_shifter.sv
module test_gated_p2s_shifter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       hold_en = 1'b0;
  logic       shift_sel = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;

  gated_p2s_shifter i_gated_p2s_shifter (
    .clk(clk), .clr_n(clr_n), .hold_en(hold_en), .shift_sel(shift_sel),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
  );

  always #10 clk = ~clk;

  // Vector: {hold, sel, ser, par[7:0]}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5}, {1'b0, 1'b1, 1'b1, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hFF}, {1'b1, 1'b1, 1'b1, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h00}, {1'b0, 1'b1, 1'b1, 8'h12},
    {1'b0, 1'b0, 1'b1, 8'h3C}, {1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'h00}, {1'b1, 1'b0, 1'b1, 8'h7E},
    {1'b0, 1'b0, 1'b0, 8'h81}, {1'b0, 1'b1, 1'b1, 8'h55}
  };

  // Reference next state, written as an explicit per-stage loop.
  function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic h,
                                          input logic s, input logic sin,
                                          input logic [7:0] p);
    logic [7:0] n;
    n = cur;
    if (!h) begin
      if (!s) n = p;
      else begin
        for (int i = 7; i >= 1; i--) n[i] = cur[i-1];
        n[0] = sin;
      end
    end
    return n;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic apply(input logic h, input logic s, input logic sin, input logic [7:0] p);
    hold_en = h; shift_sel = s; ser_in = sin; par_in = p;
    tick();
    model = ref_next(model, h, s, sin, p);
  endtask

  // Shift the whole chain out with zeros entering, comparing every stage.
  task automatic drain(input string req);
    for (int i = 0; i < 8; i++) begin
      check(ser_out, model[7], req);
      apply(1'b0, 1'b1, 1'b0, 8'h00);
    end
    check(ser_out, 1'b0, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: clear forces zero, with no edge yet and with a load pending.
    #5;
    check(ser_out, 1'b0, "R1 reset state");
    shift_sel = 1'b0; par_in = 8'hFF;
    tick();
    check(ser_out, 1'b0, "R1 clear beats load");

    // R7: release between edges; nothing happens until the next edge.
    clr_n = 1'b1; par_in = 8'h80;
    #3;
    check(ser_out, 1'b0, "R7 before first edge");
    tick();
    model = 8'h80;
    check(ser_out, 1'b1, "R7 first edge loads");

    // Table walk: R3, R4, R2, R5
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);
      check(ser_out, model[7], "R5 table step");
    end
    drain("R4 table drain");

    // R8: load then eight shifts show h..a.
    apply(1'b0, 1'b0, 1'b0, 8'hB4);
    for (int i = 7; i >= 0; i--) begin
      check(ser_out, 1'(8'hB4 >> i), "R8 drain order");
      apply(1'b0, 1'b1, 1'b0, 8'h00);
    end
    drain("R8 empty after drain");

    // R2: freeze with every other input moving, then verify content.
    apply(1'b0, 1'b0, 1'b0, 8'h6D);
    apply(1'b1, 1'b1, 1'b1, 8'h00);
    apply(1'b1, 1'b0, 1'b0, 8'hFF);
    check(ser_out, 1'b0, "R2 frozen output");
    drain("R2 frozen content");

    // R10: serial input ignored during load.
    apply(1'b0, 1'b0, 1'b1, 8'h00);
    check(ser_out, 1'b0, "R10 load ignores serial");
    drain("R10 load content");

    // R9: wiggle inputs between edges, settle before the edge.
    apply(1'b0, 1'b0, 1'b0, 8'hC3);
    shift_sel = 1'b0; par_in = 8'h00; ser_in = 1'b1;
    #4;
    shift_sel = 1'b1; par_in = 8'hFF;
    #4;
    check(ser_out, 1'b1, "R9 no effect between edges");
    hold_en = 1'b1; shift_sel = 1'b0;
    tick();
    check(ser_out, 1'b1, "R9 held");
    drain("R9 content");

    // R6: value stays through the low half of the clock.
    apply(1'b0, 1'b0, 1'b0, 8'h80);
    @(negedge clk);
    #1;
    check(ser_out, 1'b1, "R6 stable between edges");
    #5;

    // R1: asynchronous clear in mid-cycle.
    apply(1'b0, 1'b0, 1'b0, 8'hFF);
    #3;
    clr_n = 1'b0;
    #1;
    check(ser_out, 1'b0, "R1 async clear");
    tick();
    clr_n = 1'b1;
    model = 8'h00;
    drain("R1 cleared content");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule